// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Responder

This block is the target end of a serial NOR flash read path. It watches a host's chip select, serial clock and SIO0 line, recognises the dual-output fast read command, and streams bytes from a small on-chip byte array back to the host. Each serial clock carries two bits, on SIO1 and SIO0. The three host pins are resynchronised into the block's own clock domain. Serial clock edges are found by comparing successive synchronised samples, so the block needs a system clock several times faster than the serial clock.

A frame runs through four phases. First comes an 8-bit opcode and then a 24-bit address, both on SIO0 and both most significant bit first. Next comes a run of dummy clocks whose count is a parameter. Last comes the data phase, which lasts until chip select rises. The byte address advances after every byte and wraps at the top of the array, so one command can read the whole array in a loop.

The array is filled through a synchronous preload port, which stands in for prior programming. A busy input stands in for a program, erase or status-write cycle in progress; a read that arrives while it is high is refused. The pins are brought out as separate data and output-enable signals, and the pad ring builds the tri-state buffers from them.

Top module: `dread_responder`

## Requirements
- R1: After reset, and whenever chip select is high, both output enables are low, so SIO0 and SIO1 are high impedance.
- R2: The opcode is taken from SIO0 on eight rising serial clock edges after chip select falls, most significant bit first. Only the value 0x3B starts a read.
- R3: A 24-bit address follows on SIO0 on rising edges, A23 first. Only its low MEM_AW bits select a byte, and the upper bits have no effect.
- R4: After the last address bit the block waits DUMMY_CYCLES rising edges (default 8). Both outputs stay high impedance through the opcode, address and dummy phases.
- R5: In the data phase each falling serial clock edge enables both outputs and drives one bit pair. SIO1 carries bits 7, 5, 3, 1 and SIO0 carries bits 6, 4, 2, 0 of the current byte, highest pair first. The outputs hold their value between falling edges.
- R6: After the four pairs of a byte, the next falling edge sends the byte at the next higher address, so the stream continues for as long as the host clocks.
- R7: After the byte at address 2^MEM_AW-1, the stream continues from address 0.
- R8: Raising chip select during the data phase disables both outputs combinationally. The next frame starts again from the opcode.
- R9: If busy is high when the eighth opcode bit is taken, the frame is refused, and the outputs stay high impedance until chip select rises.
- R10: Any opcode other than 0x3B makes the block ignore all further clocks until chip select rises.
- R11: A byte is written into the array at ld_addr on each system clock edge where ld_en is high.
- R12: Raising chip select part way through the opcode or address clears the bit counters. The next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock, idle low |
| sio0_in | input | 1 | Host-driven SIO0 (opcode, address, dummy) |
| busy | input | 1 | High while a program, erase or status-write cycle runs; synchronous to clk |
| ld_en | input | 1 | Preload write strobe |
| ld_addr | input | MEM_AW | Preload byte address |
| ld_data | input | 8 | Preload byte |
| sio0_out | output | 1 | SIO0 data: even bits of each byte |
| sio0_oe | output | 1 | SIO0 output enable |
| sio1_out | output | 1 | SIO1 data: odd bits of each byte |
| sio1_oe | output | 1 | SIO1 output enable |

## Verification
The bench builds the block with MEM_AW = 4, a 16-byte array, and DUMMY_CYCLES = 6. The small array lets a single frame cross the wrap point and read every location. The address can therefore start in the top bytes, with junk in the upper address bits, and still fit in a short run. The non-default dummy count shows that the wait comes from the parameter rather than a fixed eight: any off-by-one in the dummy counter shifts every data bit by a pair and is caught.

// File: rtl/dread_pkg.sv
package dread_pkg;

    // Frame phases of the responder.
    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_DATA  = 3'd3,
        PH_SKIP  = 3'd4
    } phase_e;

    localparam int ADDR_BITS   = 24;
    localparam int OPCODE_BITS = 8;

endpackage

// File: rtl/dread_pin_sync.sv
module dread_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= {STAGES{RST_VAL}};
        else        ff_q <= ff_d;
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/dread_byte_mem.sv
module dread_byte_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    // Synchronous write and registered read; one cycle of read latency.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
        rd_data <= cells[rd_addr];
    end
endmodule

// File: rtl/dread_responder.sv
module dread_responder
    import dread_pkg::*;
#(
    parameter int          MEM_AW       = 8,
    parameter int          DUMMY_CYCLES = 8,
    parameter int          SYNC_STAGES  = 2,
    parameter logic [7:0]  READ_OPCODE  = 8'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sio0_in,
    input  logic              busy,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    output logic              sio0_out,
    output logic              sio0_oe,
    output logic              sio1_out,
    output logic              sio1_oe
);
    // Counter must hold the longest phase length minus one.
    localparam int CNT_MAX0   = (ADDR_BITS > OPCODE_BITS) ? ADDR_BITS : OPCODE_BITS;
    localparam int CNT_MAX    = (DUMMY_CYCLES > CNT_MAX0) ? DUMMY_CYCLES : CNT_MAX0;
    localparam int CNT_W      = $clog2(CNT_MAX);
    localparam int DUMMY_LAST = (DUMMY_CYCLES > 0) ? DUMMY_CYCLES - 1 : 0;
    localparam phase_e AFTER_ADDR = (DUMMY_CYCLES == 0) ? PH_DATA : PH_DUMMY;
    localparam int NPINS = 3;
    // Reset values of the synchronised pins: cs_n idles high, others low.
    localparam logic [NPINS-1:0] PIN_RST = 3'b001;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        opc;
        logic [MEM_AW-1:0] addr;
        logic [7:0]        sh;
        logic [1:0]        pair;
        logic [1:0]        dout;
        logic              oe;
        logic              sclk_prev;
    } state_t;

    localparam state_t ST_RESET = '{
        phase:     PH_CMD,
        cnt:       '0,
        opc:       '0,
        addr:      '0,
        sh:        '0,
        pair:      '0,
        dout:      '0,
        oe:        1'b0,
        sclk_prev: 1'b0
    };

    state_t st_d, st_q;

    // ---------------------------------------------------------------
    // Pin synchronisers: bit 0 cs_n, bit 1 sclk, bit 2 sio0.
    // ---------------------------------------------------------------
    logic [NPINS-1:0] pins_raw, pins_s;
    assign pins_raw = {sio0_in, sclk, cs_n};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        dread_pin_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (PIN_RST[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pins_raw[g]),
            .q     (pins_s[g])
        );
    end

    logic cs_s, sclk_s, sio0_s;
    assign cs_s   = pins_s[0];
    assign sclk_s = pins_s[1];
    assign sio0_s = pins_s[2];

    logic sclk_rise, sclk_fall;
    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk_s & st_q.sclk_prev;

    // ---------------------------------------------------------------
    // Byte array; read port always follows the current byte address.
    // ---------------------------------------------------------------
    logic [7:0] rd_data;

    dread_byte_mem #(.AW(MEM_AW)) u_mem (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (st_q.addr),
        .rd_data (rd_data)
    );

    // ---------------------------------------------------------------
    // Next-state logic.
    // ---------------------------------------------------------------
    logic [7:0] opc_full;
    assign opc_full = {st_q.opc[6:0], sio0_s};

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;

        if (cs_s) begin
            // Deselected: every frame restarts from the opcode.
            st_d.phase = PH_CMD;
            st_d.cnt   = '0;
            st_d.pair  = '0;
            st_d.oe    = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_CMD: begin
                    if (sclk_rise) begin
                        st_d.opc = opc_full;
                        if (st_q.cnt == CNT_W'(OPCODE_BITS - 1)) begin
                            st_d.cnt   = '0;
                            st_d.phase = (opc_full == READ_OPCODE && !busy)
                                         ? PH_ADDR : PH_SKIP;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (sclk_rise) begin
                        // Shifting keeps only the low MEM_AW address bits.
                        st_d.addr = MEM_AW'({st_q.addr, sio0_s});
                        if (st_q.cnt == CNT_W'(ADDR_BITS - 1)) begin
                            st_d.cnt   = '0;
                            st_d.phase = AFTER_ADDR;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_DUMMY: begin
                    if (sclk_rise) begin
                        if (st_q.cnt == CNT_W'(DUMMY_LAST)) begin
                            st_d.cnt   = '0;
                            st_d.phase = PH_DATA;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (sclk_fall) begin
                        st_d.oe   = 1'b1;
                        st_d.pair = st_q.pair + 1'b1;
                        if (st_q.pair == 2'd0) begin
                            // Start of a byte: take the prefetched value and
                            // move the read port on to the next address.
                            st_d.dout = rd_data[7:6];
                            st_d.sh   = {rd_data[5:0], 2'b00};
                            st_d.addr = st_q.addr + 1'b1;
                        end else begin
                            st_d.dout = st_q.sh[7:6];
                            st_d.sh   = {st_q.sh[5:0], 2'b00};
                        end
                    end
                end
                default: begin
                    // PH_SKIP: wait for chip select to rise.
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // Output enables drop with the raw chip select, without sync delay.
    assign sio1_out = st_q.dout[1];
    assign sio0_out = st_q.dout[0];
    assign sio1_oe  = st_q.oe & ~cs_n;
    assign sio0_oe  = st_q.oe & ~cs_n;

    // Views for the bound checker.
    phase_e     cur_phase;
    logic [1:0] cur_pair;
    assign cur_phase = st_q.phase;
    assign cur_pair  = st_q.pair;
endmodule

// File: rtl/dread_responder_chk.sv
module dread_responder_chk
    import dread_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_sync,
    input logic       sclk_fall,
    input phase_e     phase,
    input logic [1:0] pair,
    input logic [1:0] dout,
    input logic       sio0_oe,
    input logic       sio1_oe
);
    // R4: outputs are driven only in the data phase.
    assert_hiz_outside_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sio0_oe || sio1_oe) |-> (phase == PH_DATA));

    // R5: both pins are enabled together.
    assert_pins_paired_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sio0_oe == sio1_oe);

    // R5: data changes only after a falling serial clock edge.
    assert_hold_between_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(dout));

    // R8 / R12: deselect returns to the opcode phase with the pair index cleared.
    assert_deselect_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sync |=> (phase == PH_CMD && pair == 2'd0));

    // R10: a refused frame stays refused while selected.
    assert_skip_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP && !cs_sync) |=> (phase == PH_SKIP));
endmodule

bind dread_responder dread_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_sync   (cs_s),
    .sclk_fall (sclk_fall),
    .phase     (cur_phase),
    .pair      (cur_pair),
    .dout      ({sio1_out, sio0_out}),
    .sio0_oe   (sio0_oe),
    .sio1_oe   (sio1_oe)
);

// File: tb/dread_responder_test.sv
module dread_responder_test;
    localparam int MEM_AW = 4;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int DUMMY  = 6;
    localparam int HALF   = 6;   // system clocks per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sio0_in = 1'b0, busy = 1'b0;
    logic ld_en = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic sio0_out, sio0_oe, sio1_out, sio1_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit hiz_bad = 1'b0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;   // 50 MHz

    dread_responder #(.MEM_AW(MEM_AW), .DUMMY_CYCLES(DUMMY)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio0_in(sio0_in),
        .busy(busy), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .sio0_out(sio0_out), .sio0_oe(sio0_oe), .sio1_out(sio1_out), .sio1_oe(sio1_oe)
    );

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Host drives one bit on SIO0; outputs must stay off meanwhile (R4).
    task automatic send_bit(input logic b);
        sio0_in = b;
        clk_wait(HALF);
        if (sio0_oe || sio1_oe) hiz_bad = 1'b1;
        sclk = 1'b1;
        clk_wait(HALF);
        sclk = 1'b0;
    endtask

    task automatic start_frame(input logic [7:0] op, input logic [23:0] a);
        hiz_bad = 1'b0;
        cs_n = 1'b0;
        clk_wait(3);
        for (int i = 7; i >= 0; i--) send_bit(op[i]);
        for (int i = 23; i >= 0; i--) send_bit(a[i]);
        for (int i = 0; i < DUMMY; i++) send_bit(1'b0);
        sio0_in = 1'b0;
    endtask

    // Reads four pairs; each sample sits just before the rising edge.
    task automatic read_pairs(input int npairs, input bit exp_on,
                              output logic [7:0] b, output bit oe_ok);
        b = '0;
        oe_ok = 1'b1;
        for (int k = 0; k < npairs; k++) begin
            clk_wait(HALF);
            if (sio0_oe !== exp_on || sio1_oe !== exp_on) oe_ok = 1'b0;
            b[7-2*k] = sio1_out;
            b[6-2*k] = sio0_out;
            sclk = 1'b1;
            clk_wait(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic end_frame;
        cs_n = 1'b1;
        clk_wait(1);
        check(!sio0_oe && !sio1_oe, "R8", "oe after cs_n high", {sio1_oe, sio0_oe}, 0);
        clk_wait(6);
    endtask

    task automatic read_stream(input string req, input int start, input int nbytes);
        logic [7:0] b;
        bit ok;
        for (int i = 0; i < nbytes; i++) begin
            read_pairs(4, 1'b1, b, ok);
            check(ok, req, "oe during data", ok, 1);
            check(b === model[(start + i) % DEPTH], req, "data byte", b,
                  model[(start + i) % DEPTH]);
        end
    endtask

    task automatic t_reset;
        check(!sio0_oe && !sio1_oe, "R1", "oe after reset", {sio1_oe, sio0_oe}, 0);
    endtask

    // R11: fill the array through the preload port.
    task automatic t_preload;
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 8'hA5 ^ 8'(i * 29);
            ld_en = 1'b1;
            ld_addr = MEM_AW'(i);
            ld_data = model[i];
            clk_wait(1);
        end
        ld_en = 1'b0;
        clk_wait(2);
    endtask

    // R2 R4 R5 R6 R11: plain read of three bytes.
    task automatic t_basic;
        start_frame(8'h3B, 24'h000003);
        check(!hiz_bad, "R4", "hi-Z through opcode/address/dummy", hiz_bad, 0);
        read_stream("R5", 3, 3);
        end_frame();
    endtask

    // R3 R7: top of array with junk upper bits, running past the wrap.
    task automatic t_wrap;
        start_frame(8'h3B, 24'hABCD0E);
        read_stream("R7", 14, 4);
        end_frame();
    endtask

    // R6 R7: one frame streams the whole array and wraps back to the start.
    task automatic t_stream;
        start_frame(8'h3B, 24'h000000);
        read_stream("R6", 0, DEPTH + 2);
        end_frame();
    endtask

    // R9: busy refuses the frame; a later frame works.
    task automatic t_busy;
        logic [7:0] b;
        bit ok;
        busy = 1'b1;
        start_frame(8'h3B, 24'h000005);
        read_pairs(4, 1'b0, b, ok);
        check(ok, "R9", "oe stays low while refused", ok, 1);
        read_pairs(4, 1'b0, b, ok);
        check(ok, "R9", "oe stays low second byte", ok, 1);
        busy = 1'b0;
        end_frame();
        start_frame(8'h3B, 24'h000007);
        read_stream("R9", 7, 1);
        end_frame();
    endtask

    // R10: unknown opcode ignored until deselect.
    task automatic t_badop;
        logic [7:0] b;
        bit ok;
        start_frame(8'h03, 24'h000001);
        read_pairs(4, 1'b0, b, ok);
        check(ok, "R10", "oe low after unknown opcode", ok, 1);
        read_pairs(4, 1'b0, b, ok);
        check(ok, "R10", "oe low later in frame", ok, 1);
        end_frame();
    endtask

    // R8: deselect mid byte; next frame starts cleanly.
    task automatic t_early;
        logic [7:0] b;
        bit ok;
        start_frame(8'h3B, 24'h000009);
        read_stream("R8", 9, 1);
        read_pairs(2, 1'b1, b, ok);
        check(ok, "R8", "oe during partial byte", ok, 1);
        check(b[7:4] === model[10][7:4], "R8", "partial byte", b[7:4], model[10][7:4]);
        end_frame();
        start_frame(8'h3B, 24'h000009);
        read_stream("R8", 9, 2);
        end_frame();
    endtask

    // R12: deselect part way through the address.
    task automatic t_abort_addr;
        hiz_bad = 1'b0;
        cs_n = 1'b0;
        clk_wait(3);
        for (int i = 7; i >= 0; i--) send_bit(READ_OP[i]);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        cs_n = 1'b1;
        clk_wait(6);
        check(!hiz_bad, "R12", "no drive in aborted frame", hiz_bad, 0);
        start_frame(8'h3B, 24'h000002);
        read_stream("R12", 2, 2);
        end_frame();
    endtask

    localparam logic [7:0] READ_OP = 8'h3B;

    initial begin
        clk_wait(4);
        rst_n = 1'b1;
        clk_wait(4);
        t_reset();
        t_preload();
        t_basic();
        t_wrap();
        t_stream();
        t_busy();
        t_badop();
        t_early();
        t_abort_addr();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule